// File: doc/BRIEF.md
# Masked interrupt aggregator with message output

This block gathers eleven level-sensitive interrupt lines into a single processor interrupt that travels as a posted write. Each line is synchronised to the block clock. A change of state on a line is detected by comparing the synchronised value with its value one cycle earlier. When a line whose enable bit is set changes, the block sets a request bit. It then issues one write of a programmed data word to a programmed target address on an outbound valid/ready port.

Software reaches four registers over a simple host bus, plus the message word. Two registers clear themselves when read. The change-pending register records every change on an implemented line, whether or not the line is enabled. The request register records only changes on enabled lines. A live level register shows the synchronised line state at all times, so software can find a line that is still asserted after its handler has run. Of the eleven positions, bit 9 is not implemented. Bits 0 to 5 serve the six shared bus interrupts, bit 6 an external bus interrupt and bit 10 a serial port.

The outbound port follows valid/ready rules. Once `msg_valid` rises, it stays high and `msg_addr` and `msg_data` stay frozen until a cycle in which `msg_ready` is high. That cycle is the transfer. While a message is outstanding, further enabled changes update the request register but raise no second message. Back-pressure therefore merges interrupts into a single message; it never queues them.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset, every register (enable, request, change-pending, level and message word) reads 0 and `msg_valid` is low.
- R2: Reading the level register (offset 0x028) returns the synchronised state of the implemented lines, whatever the enable and pending state. A line change shows there within three clock edges.
- R3: A change on an implemented line sets its bit in the request register (offset 0x00C) only when its enable bit is 1. The enable register is at offset 0x018, with bit n enabling line n.
- R4: A change on any implemented line sets its bit in the change-pending register (offset 0x01C), regardless of enable. A read of that register clears it and leaves the request and level registers untouched.
- R5: A read of the request register returns its contents and clears it. If a new enabled change arrives on a bit in the same cycle as the clearing read, that bit stays set.
- R6: An enabled change, when no message is outstanding, raises `msg_valid`. The payload is `msg_addr` = bits 31:8 and `msg_data` = bits 7:0 of the message word (offset 0x004), both as held when the change is detected.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. A later write to the message word does not alter a pending payload.
- R8: Enabled changes that occur while a message is outstanding set request bits but produce no further message. After a transfer, `msg_valid` is low in the next cycle.
- R9: A line already asserted when its enable bit is set produces no message by that alone. Its next change does produce one.
- R10: Bit 9 is unimplemented. It reads 0 in every interrupt register, a write of 1 to enable bit 9 is dropped, and activity on line 9 sets no bit and sends no message. The implemented set is mask 0x5FF.
- R11: The enable register and the message word read back what was last written, with unimplemented enable bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Raw interrupt lines, asynchronous |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 12 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from `hst_addr` |
| msg_valid | output | 1 | Outbound message write is presented |
| msg_ready | input | 1 | Receiver accepts the message this cycle |
| msg_addr | output | 24 | Target address of the message write |
| msg_data | output | 8 | Data word of the message write |

## Verification
The hardest case is a read-clear of the request register whose clearing edge is the very edge at which a new enabled change lands. The stimulus raises a line and then starts the read exactly two negative edges later. That count matches the two synchroniser stages plus the detection stage, so the event and the clear meet on one bit. The read returns the old value and a second read must still show the bit. The back-pressure merge is reached by holding `msg_ready` low across a second line change and a rewrite of the message word.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_MSG   = 12'h004;
  localparam logic [REG_AW-1:0] OFS_REQ   = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_MASK  = 12'h018;
  localparam logic [REG_AW-1:0] OFS_PEND  = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_LEVEL = 12'h028;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= raw[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign lvl[i] = s2;
    assign chg[i] = s2 ^ prev;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_msg_pkg::*;
#(
  parameter int unsigned W    = 11,
  parameter logic [W-1:0] IMPL = 11'h5FF,
  parameter int unsigned DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      chg,
  input  logic [W-1:0]      lvl,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic [REG_AW-1:0] hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic [W-1:0]      evt,
  output logic [W-1:0]      req_q,
  output logic [DW-1:0]     msg_word
);
  localparam int unsigned PADW = DW - W;

  logic [W-1:0] mask_q, pend_q, chg_i;
  logic         rd, wr;

  assign rd    = hst_sel && !hst_wr;
  assign wr    = hst_sel && hst_wr;
  assign chg_i = chg & IMPL;
  assign evt   = chg_i & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      msg_word <= '0;
      req_q    <= '0;
      pend_q   <= '0;
    end else begin
      if (wr && hst_addr == OFS_MASK) mask_q <= hst_wdata[W-1:0] & IMPL;
      if (wr && hst_addr == OFS_MSG)  msg_word <= hst_wdata;
      // new events win over a same-cycle clearing read
      req_q  <= ((rd && hst_addr == OFS_REQ)  ? '0 : req_q)  | evt;
      pend_q <= ((rd && hst_addr == OFS_PEND) ? '0 : pend_q) | chg_i;
    end
  end

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      OFS_MSG:   hst_rdata = msg_word;
      OFS_REQ:   hst_rdata = {{PADW{1'b0}}, req_q};
      OFS_MASK:  hst_rdata = {{PADW{1'b0}}, mask_q};
      OFS_PEND:  hst_rdata = {{PADW{1'b0}}, pend_q};
      OFS_LEVEL: hst_rdata = {{PADW{1'b0}}, lvl & IMPL};
      default:   hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_msg_tx.sv
module irq_msg_tx #(
  parameter int unsigned DW  = 32,
  parameter int unsigned MDW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DW-1:0]     msg_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DW-MDW-1:0] out_addr,
  output logic [MDW-1:0]    out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (!out_valid) begin
      if (fire) begin
        out_valid <= 1'b1;
        out_addr  <= msg_word[DW-1:MDW];
        out_data  <= msg_word[MDW-1:0];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_msg_pkg::*;
#(
  parameter int unsigned  NIRQ  = 11,
  parameter logic [NIRQ-1:0] IMPL = 11'h5FF,
  parameter int unsigned  DW    = 32,
  parameter int unsigned  MDW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIRQ-1:0]   irq_in,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic [REG_AW-1:0] hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DW-MDW-1:0] msg_addr,
  output logic [MDW-1:0]    msg_data
);
  logic [NIRQ-1:0] lvl, chg, evt, req_q;
  logic [DW-1:0]   msg_word;

  irq_sync #(.W(NIRQ)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .lvl(lvl), .chg(chg)
  );

  irq_regs #(.W(NIRQ), .IMPL(IMPL), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .chg(chg), .lvl(lvl),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .evt(evt), .req_q(req_q), .msg_word(msg_word)
  );

  irq_msg_tx #(.DW(DW), .MDW(MDW)) u_tx (
    .clk(clk), .rst_n(rst_n), .fire(|evt), .msg_word(msg_word),
    .out_ready(msg_ready), .out_valid(msg_valid),
    .out_addr(msg_addr), .out_data(msg_data)
  );
endmodule

// File: rtl/irq_msg_agg_chk.sv
module irq_msg_agg_chk
  import irq_msg_pkg::*;
#(
  parameter int unsigned  NIRQ = 11,
  parameter logic [NIRQ-1:0] IMPL = 11'h5FF,
  parameter int unsigned  DW   = 32,
  parameter int unsigned  MDW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_sel,
  input logic              hst_wr,
  input logic [REG_AW-1:0] hst_addr,
  input logic [DW-1:0]     hst_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [DW-MDW-1:0] msg_addr,
  input logic [MDW-1:0]    msg_data,
  input logic [NIRQ-1:0]   evt,
  input logic [NIRQ-1:0]   req_q
);
  // R7: outbound payload frozen under back-pressure
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R8: a transfer always drops valid for a cycle
  p_drop_after_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  // R6: a message only starts after an enabled change
  p_msg_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|evt));

  // R5: clearing read with no colliding event empties the request register
  p_req_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && !hst_wr && hst_addr == OFS_REQ && evt == '0) |=> (req_q == '0));

  // R10: unimplemented positions read zero in interrupt registers
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && !hst_wr && hst_addr != OFS_MSG) |->
      (((hst_rdata[NIRQ-1:0] & ~IMPL) == '0) && (hst_rdata[DW-1:NIRQ] == '0)));
endmodule

bind irq_msg_agg irq_msg_agg_chk #(.NIRQ(NIRQ), .IMPL(IMPL), .DW(DW), .MDW(MDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
  .hst_addr(hst_addr), .hst_rdata(hst_rdata), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .evt(evt), .req_q(req_q)
);

// File: tb/irq_msg_agg_tb.sv
module irq_msg_agg_tb;
  import irq_msg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_in = '0;
  logic        hst_sel = 1'b0, hst_wr = 1'b0;
  logic [11:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [23:0] msg_addr;
  logic [7:0]  msg_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  logic [31:0] cur_msg;
  logic [31:0] rd;

  always #5 clk = ~clk;

  irq_msg_agg u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .hst_sel(hst_sel),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_sel = 1'b0; hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
    #3 d = hst_rdata;
    @(negedge clk);
    hst_sel = 1'b0;
  endtask

  task automatic expect_reg(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    hread(a, v);
    check(v == exp, tag, v, exp);
  endtask

  // scoreboard monitor: every accepted message must match the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected message", {msg_addr, msg_data}, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check({msg_addr, msg_data} == e, "R6 message payload", {msg_addr, msg_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    #1 check(msg_valid == 1'b0, "R1 msg_valid in reset", {31'b0, msg_valid}, 0);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    expect_reg(OFS_MASK, 0, "R1 enable reset");
    expect_reg(OFS_REQ, 0, "R1 request reset");
    expect_reg(OFS_PEND, 0, "R1 pending reset");
    expect_reg(OFS_LEVEL, 0, "R1 level reset");
    expect_reg(OFS_MSG, 0, "R1 message word reset");

    // R11 / R10 register write-back
    cur_msg = 32'hABCDE15A;
    hwrite(OFS_MSG, cur_msg);
    expect_reg(OFS_MSG, cur_msg, "R11 message word readback");
    hwrite(OFS_MASK, 32'h7FF);
    expect_reg(OFS_MASK, 32'h5FF, "R10 enable bit9 dropped");

    // R3 R6 enabled change on line 0
    exp_q.push_back(cur_msg);
    @(negedge clk) irq_in[0] = 1'b1;
    idle(6);
    expect_reg(OFS_REQ, 32'h001, "R3 request on enabled change");
    expect_reg(OFS_REQ, 32'h000, "R5 request cleared by read");
    expect_reg(OFS_PEND, 32'h001, "R4 pending set");
    expect_reg(OFS_PEND, 32'h000, "R4 pending cleared by read");
    expect_reg(OFS_LEVEL, 32'h001, "R2 level after pending clear");

    // R3 R4 disabled line: pending only, no message
    hwrite(OFS_MASK, 32'h002);
    @(negedge clk) irq_in[2] = 1'b1;
    idle(6);
    expect_reg(OFS_REQ, 32'h000, "R3 no request when disabled");
    expect_reg(OFS_PEND, 32'h004, "R4 pending regardless of enable");
    expect_reg(OFS_LEVEL, 32'h005, "R2 level ignores enable");

    // R9 line asserted before enable
    @(negedge clk) irq_in[3] = 1'b1;
    idle(6);
    hread(OFS_PEND, rd);
    hwrite(OFS_MASK, 32'h00A);
    idle(8);
    expect_reg(OFS_REQ, 32'h000, "R9 no request on enable of asserted line");
    check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
    exp_q.push_back(cur_msg);
    @(negedge clk) irq_in[3] = 1'b0;
    idle(6);
    expect_reg(OFS_REQ, 32'h008, "R9 next change requests");
    check(exp_q.size() == 0, "R9 message sent on later change", exp_q.size(), 0);

    // R10 line 9 inert
    hwrite(OFS_MASK, 32'h7FF);
    hread(OFS_PEND, rd);
    @(negedge clk) irq_in[9] = 1'b1;
    idle(6);
    expect_reg(OFS_PEND, 32'h000, "R10 line9 sets no pending");
    expect_reg(OFS_REQ, 32'h000, "R10 line9 sets no request");
    expect_reg(OFS_LEVEL, 32'h005, "R10 line9 level reads zero");

    // R7 R8 back-pressure and merge
    msg_ready = 1'b0;
    exp_q.push_back(cur_msg);
    @(negedge clk) irq_in[4] = 1'b1;
    idle(4);
    #3 check(msg_valid == 1'b1, "R7 valid raised under back-pressure", {31'b0, msg_valid}, 1);
    check({msg_addr, msg_data} == cur_msg, "R7 payload", {msg_addr, msg_data}, cur_msg);
    hwrite(OFS_MSG, 32'h13579B24);
    @(negedge clk) irq_in[5] = 1'b1;
    idle(6);
    #3 check(msg_valid == 1'b1, "R7 valid held", {31'b0, msg_valid}, 1);
    check({msg_addr, msg_data} == cur_msg, "R7 payload held after rewrite", {msg_addr, msg_data}, cur_msg);
    cur_msg = 32'h13579B24;
    @(negedge clk) msg_ready = 1'b1;
    idle(8);
    check(exp_q.size() == 0, "R8 single merged message", exp_q.size(), 0);
    expect_reg(OFS_REQ, 32'h030, "R8 both requests recorded");

    // R5 read-clear collides with new event on bit 6
    exp_q.push_back(cur_msg);
    @(negedge clk) irq_in[6] = 1'b1;
    @(negedge clk);
    hread(OFS_REQ, rd);
    check(rd == 32'h000, "R5 read before event lands", rd, 0);
    expect_reg(OFS_REQ, 32'h040, "R5 event wins over clear");
    expect_reg(OFS_REQ, 32'h000, "R5 cleared afterwards");

    idle(10);
    check(exp_q.size() == 0, "R6 all messages delivered", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule